// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a host-attached parallel I/O peripheral. It offers three 8-bit general-purpose ports (A, B and C) and one write-only control register. A host reaches them over an 8-bit three-state data bus, using an active-low chip select, active-low read and write strobes, and a 2-bit register address. Port C is split into two nibbles. The upper nibble shares a control group with port A, and the lower nibble shares one with port B. Each nibble takes its direction independently.

A single command path at the control address does two jobs, chosen by bit 7 of the written byte. With bit 7 set, the byte is a configuration word: it sets the direction of A, B and each half of C, and it clears every output latch. With bit 7 clear, the byte forces one port C output latch bit to 0 or 1. Only plain input/output operation exists: no handshaking modes and no interrupts.

The strobes are sampled on the system clock by a three-state sequencer with these states:
- `ST_IDLE`: no access.
- `ST_WRITE`: a write strobe is held.
- `ST_READ`: a read strobe is held.

The sequencer makes these transitions:
- `go_write` (ST_IDLE to ST_WRITE): a selected write with read high. The register update is issued on this transition only.
- `go_read` (ST_IDLE to ST_READ): a selected read with write high.
- `end_write` (ST_WRITE to ST_IDLE): chip select or write rises.
- `end_read` (ST_READ to ST_IDLE): the selected read request ends.

The bus is driven only in ST_READ, and only while the read request is still present. Each external pin group is presented as three vectors: the pin input, the output latch and a per-bit output enable.

Top module: `par_port_if`

## Requirements
- R1: While reset (active high) is asserted, and in the cycle after it, every output enable is 0 (all ports are inputs) and every output latch is 8'h00.
- R2: While chip select is high, no write changes any latch or direction, and the host bus is not driven even if read is low.
- R3: The host bus is driven only in ST_READ, from the first clock edge that sees chip select and read low with write high. It is released at once when that request ends.
- R4: A write to address 0, 1 or 2 loads the byte into the output latch of port A, B or C respectively, whatever that port's current direction is.
- R5: A control word (address 3) with bit 7 = 1 sets the directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 3 sets port C[7:4], bit 1 sets port B and bit 0 sets port C[3:0]. Bits 6, 5 and 2 have no effect.
- R6: A control word with bit 7 = 1 clears all three output latches to 8'h00.
- R7: A control word with bit 7 = 0 writes bit 0 into port C latch bit number {bit3,bit2,bit1}. All other latch bits and all directions are unchanged.
- R8: A read of port A, B or C returns, bit by bit, the pin input where that bit is an input and the output latch where it is an output. The two halves of port C follow their own directions.
- R9: A read of address 3 returns 8'hFF and changes no latch or direction.
- R10: With chip select low and read and write both low, nothing is written and the bus is not driven.
- R11: A write strobe held for several cycles commits exactly once, using the data present on the first clock edge of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| host_d | inout | 8 | Three-state host data bus |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
A wrong direction or latch bit shows up at the output enable or latch vector in the cycle right after the committing clock edge. The next read of that port also returns it, because the read mux mixes pin and latch by direction. A sequencer stuck outside ST_IDLE shows up on the very next access: writes stop landing, or the bus stays driven after the read strobe rises. A sequencer that recommits during a held strobe shows up as late data in a latch. The bench sweeps all 16 direction combinations, with the ignored mode bits randomised and with random pin and latch patterns. It also sweeps all 16 single-bit commands against a model computed in the bench.

// File: rtl/par_port_pkg.sv
package par_port_pkg;

    parameter int PORT_W = 8;
    localparam int HALF_W = PORT_W / 2;
    localparam int BIT_IDX_W = $clog2(PORT_W);

    localparam logic [1:0] ADDR_PA  = 2'd0;
    localparam logic [1:0] ADDR_PB  = 2'd1;
    localparam logic [1:0] ADDR_PC  = 2'd2;
    localparam logic [1:0] ADDR_CTL = 2'd3;

    // Control word field positions (decoded by the register block)
    localparam int CW_MODE_FLAG = 7;
    localparam int CW_DIR_A     = 4;
    localparam int CW_DIR_CHI   = 3;
    localparam int CW_DIR_B     = 1;
    localparam int CW_DIR_CLO   = 0;
    localparam int CW_BIT_LO    = 1;
    localparam int CW_BIT_VAL   = 0;

    localparam logic [PORT_W-1:0] CTL_READ_VALUE = '1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_state_e;

    // 1 = input, 0 = output
    typedef struct packed {
        logic a;
        logic c_hi;
        logic b;
        logic c_lo;
    } dir_cfg_t;

endpackage

// File: rtl/par_port_bus_fsm.sv
module par_port_bus_fsm
    import par_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_commit,
    output logic rd_drive
);

    bus_state_e state_q;
    bus_state_e state_d;
    logic       sel;
    logic       wr_req;
    logic       rd_req;

    assign sel    = !cs_n;
    assign wr_req = sel && !wr_n && rd_n;
    assign rd_req = sel && !rd_n && wr_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: go_write, go_read, end_write, end_read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req) begin
                    state_d = ST_WRITE;
                end else if (rd_req) begin
                    state_d = ST_READ;
                end
            end
            ST_WRITE: begin
                if (!(sel && !wr_n)) begin
                    state_d = ST_IDLE;
                end
            end
            ST_READ: begin
                if (!rd_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_commit = 1'b0;
        rd_drive  = 1'b0;
        unique case (state_q)
            ST_IDLE:  wr_commit = wr_req;
            ST_WRITE: wr_commit = 1'b0;
            ST_READ:  rd_drive  = rd_req;
            default: begin
                wr_commit = 1'b0;
                rd_drive  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/par_port_cfg_regs.sv
module par_port_cfg_regs
    import par_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wdata,
    output dir_cfg_t          dir,
    output logic [PORT_W-1:0] lat_a,
    output logic [PORT_W-1:0] lat_b,
    output logic [PORT_W-1:0] lat_c
);

    logic [BIT_IDX_W-1:0] bsr_idx;
    assign bsr_idx = wdata[CW_BIT_LO +: BIT_IDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir   <= '{a: 1'b1, c_hi: 1'b1, b: 1'b1, c_lo: 1'b1};
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
        end else if (commit) begin
            unique case (addr)
                ADDR_PA: lat_a <= wdata;
                ADDR_PB: lat_b <= wdata;
                ADDR_PC: lat_c <= wdata;
                ADDR_CTL: begin
                    if (wdata[CW_MODE_FLAG]) begin
                        dir.a    <= wdata[CW_DIR_A];
                        dir.c_hi <= wdata[CW_DIR_CHI];
                        dir.b    <= wdata[CW_DIR_B];
                        dir.c_lo <= wdata[CW_DIR_CLO];
                        lat_a    <= '0;
                        lat_b    <= '0;
                        lat_c    <= '0;
                    end else begin
                        lat_c[bsr_idx] <= wdata[CW_BIT_VAL];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/par_port_read_mux.sv
module par_port_read_mux
    import par_port_pkg::*;
(
    input  logic [1:0]        addr,
    input  dir_cfg_t          dir,
    input  logic [PORT_W-1:0] lat_a,
    input  logic [PORT_W-1:0] lat_b,
    input  logic [PORT_W-1:0] lat_c,
    input  logic [PORT_W-1:0] pin_a,
    input  logic [PORT_W-1:0] pin_b,
    input  logic [PORT_W-1:0] pin_c,
    output logic [PORT_W-1:0] oe_a,
    output logic [PORT_W-1:0] oe_b,
    output logic [PORT_W-1:0] oe_c,
    output logic [PORT_W-1:0] rdata
);

    logic [PORT_W-1:0] view_a;
    logic [PORT_W-1:0] view_b;
    logic [PORT_W-1:0] view_c;

    assign oe_a = {PORT_W{!dir.a}};
    assign oe_b = {PORT_W{!dir.b}};

    for (genvar i = 0; i < PORT_W; i++) begin : g_cbit
        if (i >= HALF_W) begin : g_hi
            assign oe_c[i] = !dir.c_hi;
        end else begin : g_lo
            assign oe_c[i] = !dir.c_lo;
        end
    end

    assign view_a = (oe_a & lat_a) | (~oe_a & pin_a);
    assign view_b = (oe_b & lat_b) | (~oe_b & pin_b);
    assign view_c = (oe_c & lat_c) | (~oe_c & pin_c);

    always_comb begin
        unique case (addr)
            ADDR_PA:  rdata = view_a;
            ADDR_PB:  rdata = view_b;
            ADDR_PC:  rdata = view_c;
            default:  rdata = CTL_READ_VALUE;
        endcase
    end

endmodule

// File: rtl/par_port_if.sv
module par_port_if
    import par_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    inout  wire  [PORT_W-1:0] host_d,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);

    logic              wr_commit;
    logic              rd_drive;
    dir_cfg_t          dir;
    logic [PORT_W-1:0] rd_data;
    logic [PORT_W-1:0] bus_in;

    assign bus_in = host_d;
    assign host_d = rd_drive ? rd_data : {PORT_W{1'bz}};

    par_port_bus_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .wr_commit (wr_commit),
        .rd_drive  (rd_drive)
    );

    par_port_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .commit (wr_commit),
        .addr   (addr),
        .wdata  (bus_in),
        .dir    (dir),
        .lat_a  (pa_out),
        .lat_b  (pb_out),
        .lat_c  (pc_out)
    );

    par_port_read_mux u_rmux (
        .addr  (addr),
        .dir   (dir),
        .lat_a (pa_out),
        .lat_b (pb_out),
        .lat_c (pc_out),
        .pin_a (pa_in),
        .pin_b (pb_in),
        .pin_c (pc_in),
        .oe_a  (pa_oe),
        .oe_b  (pb_oe),
        .oe_c  (pc_oe),
        .rdata (rd_data)
    );

endmodule

// File: rtl/par_port_chk.sv
module par_port_chk
    import par_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [1:0]        addr,
    input logic [PORT_W-1:0] bus_in,
    input logic              wr_commit,
    input logic              rd_drive,
    input logic [PORT_W-1:0] rd_data,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] pb_out,
    input logic [PORT_W-1:0] pc_out,
    input logic [PORT_W-1:0] pa_oe,
    input logic [PORT_W-1:0] pb_oe,
    input logic [PORT_W-1:0] pc_oe
);

    // R1
    reset_inputs_chk: assert property (@(posedge clk)
        rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                 pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!wr_commit && !rd_drive));

    // R3
    drive_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_drive |-> (!cs_n && !rd_n && wr_n));

    // R6
    mode_clears_latches_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_commit && addr == ADDR_CTL && bus_in[CW_MODE_FLAG])
            |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R7
    bsr_keeps_dirs_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_commit && addr == ADDR_CTL && !bus_in[CW_MODE_FLAG])
            |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
                 $stable(pa_out) && $stable(pb_out)));

    // R9
    ctl_read_value_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_drive && addr == ADDR_CTL) |-> (rd_data == CTL_READ_VALUE));

    // R10
    both_strobes_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wr_n) |-> (!wr_commit && !rd_drive));

    // R11
    single_commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);

endmodule

bind par_port_if par_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .bus_in    (bus_in),
    .wr_commit (wr_commit),
    .rd_drive  (rd_drive),
    .rd_data   (rd_data),
    .pa_out    (pa_out),
    .pb_out    (pb_out),
    .pc_out    (pc_out),
    .pa_oe     (pa_oe),
    .pb_oe     (pb_oe),
    .pc_oe     (pc_oe)
);

// File: tb/test_par_port_if.sv
module test_par_port_if;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_val = 8'h00;
    wire  [7:0] dbus;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // model: 1 = input
    logic dA = 1, dB = 1, dCH = 1, dCL = 1;
    logic [7:0] mA = 0, mB = 0, mC = 0;

    assign dbus = tb_drv ? tb_val : 8'bz;

    always #5 clk = ~clk;

    par_port_if i_par_port_if (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .host_d(dbus),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ports(input string req);
        logic [7:0] ec;
        ec = {{4{!dCH}}, {4{!dCL}}};
        check(pa_oe == {8{!dA}} && pb_oe == {8{!dB}} && pc_oe == ec, req,
              {8'h0, pa_oe, pb_oe, pc_oe}, {8'h0, {8{!dA}}, {8{!dB}}, ec});
        check(pa_out == mA && pb_out == mB && pc_out == mC, req,
              {8'h0, pa_out, pb_out, pc_out}, {8'h0, mA, mB, mC});
    endtask

    function automatic logic [7:0] mix(input logic [7:0] oe, input logic [7:0] lat,
                                       input logic [7:0] pin);
        return (oe & lat) | (~oe & pin);
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return mix({8{!dA}}, mA, pa_in);
            2'd1: return mix({8{!dB}}, mB, pb_in);
            2'd2: return mix({{4{!dCH}}, {4{!dCL}}}, mC, pc_in);
            default: return 8'hFF;
        endcase
    endfunction

    // one bus access of one strobe cycle; returns bus value seen after the edge
    task automatic access(input logic cs, input logic rd, input logic wr,
                          input logic [1:0] a, input logic [7:0] d,
                          input bit drv, output logic [7:0] seen);
        @(negedge clk);
        cs_n = cs; rd_n = rd; wr_n = wr; addr = a; tb_val = d; tb_drv = drv;
        @(negedge clk);
        seen = dbus;
        cs_n = 1; rd_n = 1; wr_n = 1; tb_drv = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] s;
        access(0, 1, 0, a, d, 1, s);
    endtask

    task automatic rd_check(input logic [1:0] a, input string req);
        logic [7:0] s;
        logic [7:0] e;
        e = exp_read(a);
        access(0, 0, 1, a, 8'h00, 0, s);
        check(s === e, req, {24'h0, s}, {24'h0, e});
    endtask

    task automatic model_mode(input logic [7:0] cw);
        dA = cw[4]; dCH = cw[3]; dB = cw[1]; dCL = cw[0];
        mA = 0; mB = 0; mC = 0;
    endtask

    initial begin : watchdog
        #2000000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] s;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_ports("R1 during reset");
        rst = 0;
        @(negedge clk);
        check_ports("R1 after reset");

        // R9: control read gives FF and changes nothing
        rd_check(2'd3, "R9 ctrl read");
        check_ports("R9 no state change");

        // R5/R6/R4/R8: sweep all direction combinations
        for (int m = 0; m < 16; m++) begin
            logic [7:0] cw;
            cw = {1'b1, 2'($urandom), m[3], m[2], 1'($urandom), m[1], m[0]};
            // preload latches so the clear is visible
            wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h96);
            mA = 8'hA5; mB = 8'h3C; mC = 8'h96;
            wr(2'd3, cw);
            model_mode(cw);
            check_ports("R5 R6 mode word");
            for (int k = 0; k < 4; k++) begin
                logic [7:0] va, vb, vc;
                va = 8'($urandom); vb = 8'($urandom); vc = 8'($urandom);
                wr(2'd0, va); wr(2'd1, vb); wr(2'd2, vc);
                mA = va; mB = vb; mC = vc;
                check_ports("R4 port write");
                pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
                rd_check(2'd0, "R8 read A");
                rd_check(2'd1, "R8 read B");
                rd_check(2'd2, "R8 read C");
            end
        end

        // R7: single-bit commands over every bit and value, mixed directions
        wr(2'd3, 8'h89); model_mode(8'h89);
        wr(2'd0, 8'h5A); mA = 8'h5A;
        wr(2'd1, 8'hC3); mB = 8'hC3;
        for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 2; v++) begin
                logic [7:0] cw;
                cw = {1'b0, 3'($urandom), b[2:0], v[0]};
                wr(2'd3, cw);
                mC[b] = v[0];
                check_ports("R7 bit command");
            end
        end

        // R2: deselected write ignored, deselected read leaves bus to bench
        access(1, 1, 0, 2'd0, 8'hFF, 1, s);
        check_ports("R2 deselected write");
        access(1, 0, 1, 2'd1, 8'h6E, 1, s);
        check(s === 8'h6E, "R2 R3 bus released when deselected", {24'h0, s}, 32'h6E);

        // R10: both strobes low does nothing
        access(0, 0, 0, 2'd1, 8'h11, 1, s);
        check(s === 8'h11, "R10 bus not driven", {24'h0, s}, 32'h11);
        check_ports("R10 no write");

        // R3: drive appears after the strobe edge, gone once read rises
        @(negedge clk);
        cs_n = 0; rd_n = 0; addr = 2'd3;
        @(negedge clk);
        check(dbus === 8'hFF, "R3 driven in read", {24'h0, dbus}, 32'hFF);
        rd_n = 1; tb_drv = 1; tb_val = 8'h24;
        #1;
        check(dbus === 8'h24, "R3 released at strobe end", {24'h0, dbus}, 32'h24);
        cs_n = 1; tb_drv = 0;
        @(negedge clk);

        // R11: held write commits only first data
        @(negedge clk);
        cs_n = 0; wr_n = 0; addr = 2'd0; tb_drv = 1; tb_val = 8'h77;
        @(negedge clk);
        tb_val = 8'h88;
        repeat (3) @(negedge clk);
        cs_n = 1; wr_n = 1; tb_drv = 0;
        @(negedge clk);
        mA = 8'h77;
        check_ports("R11 held strobe");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule